// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block keeps the event statistics of a 10 Gb Ethernet MAC. The receive and transmit datapaths raise one-cycle strobes, one per event kind. Each strobe advances its own counter. The four octet counters instead add the byte count of the finished frame (0 to 9600), taken from a receive-side or a transmit-side byte input. Every counter is CNT_W bits wide (40 by default). When a counter wraps past its maximum it raises a sticky rollover flag. The flag can drive an interrupt output through a per-counter enable.

Software works through a 16-bit register port with separate write and read strobes. Counters are never read live. A snapshot command copies every live counter into a holding register on the same clock edge. Software then reads each holding value as three 16-bit slices while the live counters keep running. A clear command zeroes the live counters. The rollover words clear themselves when they are read, so an overflow handler reads each word once and learns which counters wrapped.

Top module: `mstat_bank`

## Requirements
- R1: Counter n is read at word address 16+4n+k. Slice k=0 returns bits 15:0. Slice k=1 returns bits 31:16. Slice k=2 returns bits 39:32 in data bits 7:0, with bits 15:8 zero. Any counter bit at or above CNT_W reads as zero.
- R2: The counter index order is fixed:
  - Receive side: 0 octets, 1 unicast, 2 multicast, 3 broadcast, 4 pause, 5 FCS error, 6 symbol error, 7 too long, 8 jabber, 9 fragment, 10 undersized, 11 jumbo frames, 12 jumbo octets.
  - Transmit side: 13 octets, 14 internal MAC error, 15 system error, 16 unicast, 17 multicast, 18 broadcast, 19 pause, 20 jumbo frames, 21 jumbo octets.
  - A counter whose strobe bit is high on a clock edge adds one. Counters 0 and 12 add instead the receive byte count, and counters 13 and 21 add the transmit byte count.
- R3: A write to the control register (address 0) with data bit 1 set zeroes every live counter. A clear takes priority over an event in the same cycle.
- R4: A write to the control register with data bit 0 set copies every live counter, as it stood before that edge, into its holding register. Counter reads return the holding registers, which keep their values until the next snapshot while events continue to count.
- R5: A write to the control register with both bits set captures the values from before the clear into the holding registers and zeroes the live counters.
- R6: A counter wrap sets rollover flag n, bit n of a 64-bit vector read at addresses 4 to 7 (word w holds flags 16w+15 down to 16w). A flag stays set until its word is read, and a clear command does not affect it.
- R7: A read of a rollover word returns its flags and then clears that word. A wrap in the same cycle as the read leaves its flag set.
- R8: The interrupt enable words at addresses 8 to 11 are read/write and reset to zero. ovf_irq is high exactly when some rollover flag is set together with its enable bit.
- R9: Read data appears on reg_rd_data in the cycle after reg_rd_en. The control register and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_strobe | input | 22 | One-cycle event strobes, bit n feeds counter n |
| rx_frame_bytes | input | BYTES_W | Byte count for the receive octet counters |
| tx_frame_bytes | input | BYTES_W | Byte count for the transmit octet counters |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Register write word address |
| reg_wr_data | input | 16 | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | ADDR_W | Register read word address |
| reg_rd_data | output | 16 | Registered read data |
| ovf_irq | output | 1 | Overflow interrupt |

## Verification
Every cycle, the assertions check the following:
- A clear command leaves counter 0 at zero.
- Counter 0 never falls without a clear unless its rollover flag is up.
- Rollover flags drop only after a read of a rollover word.
- A rollover read returns the flags held before the read.
- Slice 2 carries no data above bit 7, and the control register reads as zero.
- The interrupt stays low while every enable bit is clear.

Only the bench scenarios can show the following:
- The exact counts, including the split of byte counts between the receive and transmit octet counters.
- That a snapshot freezes values while events continue to count.
- How a clear and a snapshot in the same write interact.
- A real wrap of two counters in different rollover words, with one flag masked from the interrupt and one enabled.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

   localparam int NUM_CNT    = 22;
   localparam int DATA_W     = 16;
   localparam int ROLL_WORDS = 4;
   localparam int FLAG_W     = ROLL_WORDS * DATA_W;
   localparam int MAX_CNT_W  = 40;
   localparam int MIN_CNT_W  = 17;

   // word addresses of the register map
   localparam int REG_CTRL      = 0;
   localparam int REG_ROLL_BASE = 4;
   localparam int REG_IEN_BASE  = 8;
   localparam int REG_CNT_BASE  = 16;
   localparam int CTRL_SNAP_BIT = 0;
   localparam int CTRL_CLR_BIT  = 1;

   // counter indices
   localparam int IX_RX_OCTETS     = 0;
   localparam int IX_RX_JUMBO_OCT  = 12;
   localparam int IX_TX_OCTETS     = 13;
   localparam int IX_TX_JUMBO_OCT  = 21;

   typedef enum logic [1:0] {
      KIND_EVENT    = 2'd0,
      KIND_RX_BYTES = 2'd1,
      KIND_TX_BYTES = 2'd2
   } cnt_kind_e;

   function automatic cnt_kind_e kind_of(input int idx);
      if (idx == IX_RX_OCTETS || idx == IX_RX_JUMBO_OCT) return KIND_RX_BYTES;
      if (idx == IX_TX_OCTETS || idx == IX_TX_JUMBO_OCT) return KIND_TX_BYTES;
      return KIND_EVENT;
   endfunction

endpackage

// File: rtl/mstat_counter.sv
module mstat_counter #(
   parameter int                   CNT_W   = 40,
   parameter int                   BYTES_W = 14,
   parameter mstat_pkg::cnt_kind_e KIND    = mstat_pkg::KIND_EVENT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               strobe,
   input  logic [BYTES_W-1:0] rx_bytes,
   input  logic [BYTES_W-1:0] tx_bytes,
   input  logic               clear,
   input  logic               snap,
   output logic [CNT_W-1:0]   live_q,
   output logic [CNT_W-1:0]   hold_q,
   output logic               wrap
);
   localparam bool_is_event = (KIND == mstat_pkg::KIND_EVENT);
   localparam bool_is_tx    = (KIND == mstat_pkg::KIND_TX_BYTES);

   logic [BYTES_W-1:0] bytes_sel;
   logic [CNT_W-1:0]   inc;
   logic [CNT_W:0]     sum;

   assign bytes_sel = bool_is_tx ? tx_bytes : rx_bytes;
   assign inc       = bool_is_event ? CNT_W'(1) : CNT_W'(bytes_sel);
   assign sum       = {1'b0, live_q} + {1'b0, inc};
   // a clear in the same cycle suppresses both the add and the wrap
   assign wrap      = strobe && !clear && sum[CNT_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= '0;
      end else if (clear) begin
         live_q <= '0;
      end else if (strobe) begin
         live_q <= sum[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (snap) begin
         hold_q <= live_q;
      end
   end
endmodule

// File: rtl/mstat_rollover.sv
module mstat_rollover #(
   parameter int NUM_CNT    = 22,
   parameter int ROLL_WORDS = 4,
   parameter int DATA_W     = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_CNT-1:0]           wrap_vec,
   input  logic [ROLL_WORDS-1:0]        rd_clr,
   input  logic [ROLL_WORDS-1:0]        ien_we,
   input  logic [DATA_W-1:0]            wdata,
   output logic [ROLL_WORDS*DATA_W-1:0] flags,
   output logic [ROLL_WORDS*DATA_W-1:0] ien,
   output logic                         irq
);
   localparam int FLAG_W = ROLL_WORDS * DATA_W;

   logic [FLAG_W-1:0] set_vec;
   assign set_vec = FLAG_W'(wrap_vec);

   for (genvar w = 0; w < ROLL_WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flags[w*DATA_W +: DATA_W] <= '0;
         end else if (rd_clr[w]) begin
            // the word read is cleared, a wrap in this cycle survives
            flags[w*DATA_W +: DATA_W] <= set_vec[w*DATA_W +: DATA_W];
         end else begin
            flags[w*DATA_W +: DATA_W] <= flags[w*DATA_W +: DATA_W]
                                         | set_vec[w*DATA_W +: DATA_W];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ien[w*DATA_W +: DATA_W] <= '0;
         end else if (ien_we[w]) begin
            ien[w*DATA_W +: DATA_W] <= wdata;
         end
      end
   end

   assign irq = |(flags & ien);
endmodule

// File: rtl/mstat_regif.sv
module mstat_regif #(
   parameter int ADDR_W     = 8,
   parameter int NUM_CNT    = 22,
   parameter int CNT_W      = 40,
   parameter int ROLL_WORDS = 4,
   parameter int DATA_W     = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic                         rd_en,
   input  logic [ADDR_W-1:0]            rd_addr,
   input  logic [ROLL_WORDS*DATA_W-1:0] flags,
   input  logic [ROLL_WORDS*DATA_W-1:0] ien,
   input  logic [NUM_CNT*CNT_W-1:0]     hold_flat,
   output logic                         snap,
   output logic                         clear,
   output logic [ROLL_WORDS-1:0]        ien_we,
   output logic [ROLL_WORDS-1:0]        roll_rd,
   output logic [DATA_W-1:0]            rd_data
);
   localparam int WIDE_W  = 3 * DATA_W;
   localparam int PAD_W   = WIDE_W - CNT_W;
   localparam int IDX_W   = ADDR_W - 2;
   localparam int CNT_END = mstat_pkg::REG_CNT_BASE + 4 * NUM_CNT;

   logic              ctrl_wr;
   logic [ADDR_W-1:0] cnt_off;
   logic [IDX_W-1:0]  cnt_idx;
   logic              cnt_hit;
   logic [CNT_W-1:0]  sel;
   logic [WIDE_W-1:0] wide;
   logic [DATA_W-1:0] rd_next;

   assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(mstat_pkg::REG_CTRL));
   assign snap    = ctrl_wr && wr_data[mstat_pkg::CTRL_SNAP_BIT];
   assign clear   = ctrl_wr && wr_data[mstat_pkg::CTRL_CLR_BIT];

   for (genvar w = 0; w < ROLL_WORDS; w++) begin : g_dec
      assign ien_we[w]  = wr_en && (wr_addr == ADDR_W'(mstat_pkg::REG_IEN_BASE + w));
      assign roll_rd[w] = rd_en && (rd_addr == ADDR_W'(mstat_pkg::REG_ROLL_BASE + w));
   end

   assign cnt_off = rd_addr - ADDR_W'(mstat_pkg::REG_CNT_BASE);
   assign cnt_idx = cnt_off[ADDR_W-1:2];
   assign cnt_hit = (rd_addr >= ADDR_W'(mstat_pkg::REG_CNT_BASE))
                    && (rd_addr < ADDR_W'(CNT_END));

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (cnt_idx == IDX_W'(i)) sel = hold_flat[i*CNT_W +: CNT_W];
      end
   end

   // widen every counter to three full slices; the bits above CNT_W stay zero
   if (PAD_W > 0) begin : g_pad
      assign wide = {{PAD_W{1'b0}}, sel};
   end else begin : g_nopad
      assign wide = sel;
   end

   always_comb begin
      rd_next = '0;
      for (int w = 0; w < ROLL_WORDS; w++) begin
         if (rd_addr == ADDR_W'(mstat_pkg::REG_ROLL_BASE + w))
            rd_next = flags[w*DATA_W +: DATA_W];
         if (rd_addr == ADDR_W'(mstat_pkg::REG_IEN_BASE + w))
            rd_next = ien[w*DATA_W +: DATA_W];
      end
      if (cnt_hit) begin
         case (rd_addr[1:0])
            2'd0:    rd_next = wide[DATA_W-1:0];
            2'd1:    rd_next = wide[2*DATA_W-1:DATA_W];
            2'd2:    rd_next = {8'h00, wide[2*DATA_W+7:2*DATA_W]};
            default: rd_next = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         rd_data <= rd_next;
      end
   end
endmodule

// File: rtl/mstat_bank.sv
module mstat_bank #(
   parameter int CNT_W   = 40,
   parameter int BYTES_W = 14,
   parameter int ADDR_W  = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [mstat_pkg::NUM_CNT-1:0] evt_strobe,
   input  logic [BYTES_W-1:0]            rx_frame_bytes,
   input  logic [BYTES_W-1:0]            tx_frame_bytes,
   input  logic                          reg_wr_en,
   input  logic [ADDR_W-1:0]             reg_wr_addr,
   input  logic [mstat_pkg::DATA_W-1:0]  reg_wr_data,
   input  logic                          reg_rd_en,
   input  logic [ADDR_W-1:0]             reg_rd_addr,
   output logic [mstat_pkg::DATA_W-1:0]  reg_rd_data,
   output logic                          ovf_irq
);
   localparam int NUM_CNT    = mstat_pkg::NUM_CNT;
   localparam int DATA_W     = mstat_pkg::DATA_W;
   localparam int ROLL_WORDS = mstat_pkg::ROLL_WORDS;
   localparam int FLAG_W     = mstat_pkg::FLAG_W;
   localparam int MAP_END    = mstat_pkg::REG_CNT_BASE + 4 * NUM_CNT;

   if (CNT_W < mstat_pkg::MIN_CNT_W || CNT_W > mstat_pkg::MAX_CNT_W) begin : g_bad_cnt_w
      $error("mstat_bank: CNT_W must lie between 17 and 40");
   end
   if (BYTES_W >= CNT_W || BYTES_W < 14) begin : g_bad_bytes_w
      $error("mstat_bank: BYTES_W must hold 9600 and stay below CNT_W");
   end
   if ((1 << ADDR_W) < MAP_END) begin : g_bad_addr_w
      $error("mstat_bank: ADDR_W too small for the register map");
   end
   if (NUM_CNT > FLAG_W) begin : g_bad_num
      $error("mstat_bank: more counters than rollover flags");
   end

   logic                   snap;
   logic                   clear;
   logic [ROLL_WORDS-1:0]  ien_we;
   logic [ROLL_WORDS-1:0]  roll_rd;
   logic [NUM_CNT-1:0]     wrap_vec;
   logic [NUM_CNT*CNT_W-1:0] live_flat;
   logic [NUM_CNT*CNT_W-1:0] hold_flat;
   logic [FLAG_W-1:0]      roll_flags;
   logic [FLAG_W-1:0]      ien_bits;

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      mstat_counter #(
         .CNT_W   (CNT_W),
         .BYTES_W (BYTES_W),
         .KIND    (mstat_pkg::kind_of(i))
      ) cnt_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .strobe   (evt_strobe[i]),
         .rx_bytes (rx_frame_bytes),
         .tx_bytes (tx_frame_bytes),
         .clear    (clear),
         .snap     (snap),
         .live_q   (live_flat[i*CNT_W +: CNT_W]),
         .hold_q   (hold_flat[i*CNT_W +: CNT_W]),
         .wrap     (wrap_vec[i])
      );
   end

   mstat_rollover #(
      .NUM_CNT    (NUM_CNT),
      .ROLL_WORDS (ROLL_WORDS),
      .DATA_W     (DATA_W)
   ) roll_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wrap_vec (wrap_vec),
      .rd_clr   (roll_rd),
      .ien_we   (ien_we),
      .wdata    (reg_wr_data),
      .flags    (roll_flags),
      .ien      (ien_bits),
      .irq      (ovf_irq)
   );

   mstat_regif #(
      .ADDR_W     (ADDR_W),
      .NUM_CNT    (NUM_CNT),
      .CNT_W      (CNT_W),
      .ROLL_WORDS (ROLL_WORDS),
      .DATA_W     (DATA_W)
   ) regif_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr_en),
      .wr_addr   (reg_wr_addr),
      .wr_data   (reg_wr_data),
      .rd_en     (reg_rd_en),
      .rd_addr   (reg_rd_addr),
      .flags     (roll_flags),
      .ien       (ien_bits),
      .hold_flat (hold_flat),
      .snap      (snap),
      .clear     (clear),
      .ien_we    (ien_we),
      .roll_rd   (roll_rd),
      .rd_data   (reg_rd_data)
   );
endmodule

// File: rtl/mstat_bank_chk.sv
module mstat_bank_chk #(
   parameter int CNT_W  = 40,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_en,
   input logic [ADDR_W-1:0] reg_wr_addr,
   input logic [15:0]       reg_wr_data,
   input logic              reg_rd_en,
   input logic [ADDR_W-1:0] reg_rd_addr,
   input logic [15:0]       reg_rd_data,
   input logic              ovf_irq,
   input logic [CNT_W-1:0]  cnt0,
   input logic [63:0]       flags,
   input logic [63:0]       ien
);
   logic clr_cmd;
   logic roll_read;
   assign clr_cmd   = reg_wr_en && (reg_wr_addr == ADDR_W'(0)) && reg_wr_data[1];
   assign roll_read = reg_rd_en && (reg_rd_addr >= ADDR_W'(4)) && (reg_rd_addr <= ADDR_W'(7));

   AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_cmd |=> (cnt0 == '0)); // R3

   AST_NO_SILENT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_cmd |=> ((cnt0 >= $past(cnt0)) || flags[0])); // R2

   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !roll_read |=> ((flags & $past(flags)) == $past(flags))); // R6

   AST_ROLL_READ_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_en && reg_rd_addr == ADDR_W'(4)) |=> (reg_rd_data == $past(flags[15:0]))); // R7

   AST_SLICE2_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_en && reg_rd_addr >= ADDR_W'(16) && reg_rd_addr[1:0] == 2'd2)
      |=> (reg_rd_data[15:8] == 8'h00)); // R1

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == '0) |-> !ovf_irq); // R8

   AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_en && reg_rd_addr == ADDR_W'(0)) |=> (reg_rd_data == 16'h0000)); // R9
endmodule

bind mstat_bank mstat_bank_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr_en   (reg_wr_en),
   .reg_wr_addr (reg_wr_addr),
   .reg_wr_data (reg_wr_data),
   .reg_rd_en   (reg_rd_en),
   .reg_rd_addr (reg_rd_addr),
   .reg_rd_data (reg_rd_data),
   .ovf_irq     (ovf_irq),
   .cnt0        (live_flat[CNT_W-1:0]),
   .flags       (roll_flags),
   .ien         (ien_bits)
);

// File: tb/mstat_bank_tb_top.sv
module mstat_bank_tb_top;
   localparam int CNT_W   = 20;
   localparam int BYTES_W = 14;
   localparam int ADDR_W  = 8;
   localparam int NCNT    = 22;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NCNT-1:0]   evt_strobe = '0;
   logic [BYTES_W-1:0] rx_frame_bytes = '0;
   logic [BYTES_W-1:0] tx_frame_bytes = '0;
   logic              reg_wr_en = 1'b0;
   logic [ADDR_W-1:0] reg_wr_addr = '0;
   logic [15:0]       reg_wr_data = '0;
   logic              reg_rd_en = 1'b0;
   logic [ADDR_W-1:0] reg_rd_addr = '0;
   logic [15:0]       reg_rd_data;
   logic              ovf_irq;

   int n_checks = 0;
   int n_errors = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;

   always #5 clk = ~clk;

   mstat_bank #(.CNT_W(CNT_W), .BYTES_W(BYTES_W), .ADDR_W(ADDR_W)) dut_i (
      .clk, .rst_n, .evt_strobe, .rx_frame_bytes, .tx_frame_bytes,
      .reg_wr_en, .reg_wr_addr, .reg_wr_data, .reg_rd_en, .reg_rd_addr,
      .reg_rd_data, .ovf_irq
   );

   function automatic logic [7:0] caddr(input int n, input int k);
      return 8'(16 + 4 * n + k);
   endfunction

   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: compares each read one cycle after it was issued
   always @(posedge clk) rd_seen <= reg_rd_en;
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) begin
         logic [15:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(reg_rd_data, e, t);
      end
   end

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [15:0] e, input string tag);
      reg_rd_en = 1'b1; reg_rd_addr = a;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      reg_rd_en = 1'b0;
   endtask

   task automatic pulse(input logic [NCNT-1:0] v, input int rxb, input int txb);
      evt_strobe = v; rx_frame_bytes = BYTES_W'(rxb); tx_frame_bytes = BYTES_W'(txb);
      @(negedge clk);
      evt_strobe = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      rd(8'd0, 16'h0000, "R9 ctrl reads zero");
      rd(caddr(1, 0), 16'h0000, "R4 holding reset");
      rd(8'd4, 16'h0000, "R6 rollover reset");
      rd(8'd8, 16'h0000, "R8 enable reset");
      rd(8'hFF, 16'h0000, "R9 unmapped reads zero");
      check(16'(ovf_irq), 16'h0, "R8 irq reset");

      // event and octet counting
      for (int i = 0; i < 5; i++) pulse(22'(1) << 1, 0, 0);
      pulse(22'(1), 64, 0);
      pulse(22'(1), 1500, 0);
      pulse(22'(1), 9600, 0);
      pulse(22'(1) << 13, 3000, 100);
      wr(8'd0, 16'h0001);
      rd(caddr(1, 0), 16'd5, "R2 unicast count");
      rd(caddr(0, 0), 16'd11164, "R2 rx octets low");
      rd(caddr(0, 1), 16'd0, "R1 rx octets mid");
      rd(caddr(13, 0), 16'd100, "R2 tx octets use tx bytes");

      // events keep counting, holding frozen
      for (int i = 0; i < 3; i++) pulse(22'(1) << 1, 0, 0);
      rd(caddr(1, 0), 16'd5, "R4 holding frozen");
      wr(8'd0, 16'h0001);
      rd(caddr(1, 0), 16'd8, "R4 next snapshot");

      // all strobes at once
      pulse('1, 10, 20);
      wr(8'd0, 16'h0001);
      rd(caddr(1, 0), 16'd9, "R2 unicast joint");
      rd(caddr(7, 0), 16'd1, "R2 too long joint");
      rd(caddr(12, 0), 16'd10, "R2 rx jumbo octets");
      rd(caddr(21, 0), 16'd20, "R2 tx jumbo octets");
      rd(caddr(20, 0), 16'd1, "R2 tx jumbo frames");

      // clear beats a same-cycle event
      evt_strobe = 22'(1) << 1;
      wr(8'd0, 16'h0002);
      evt_strobe = '0;
      wr(8'd0, 16'h0001);
      rd(caddr(1, 0), 16'd0, "R3 clear wins over event");
      rd(caddr(0, 0), 16'd0, "R3 octets cleared");

      // snapshot and clear in one write
      for (int i = 0; i < 4; i++) pulse(22'(1) << 2, 0, 0);
      wr(8'd0, 16'h0003);
      rd(caddr(2, 0), 16'd4, "R5 pre-clear value captured");
      wr(8'd0, 16'h0001);
      rd(caddr(2, 0), 16'd0, "R5 live counter zeroed");

      // wrap of counters 0 and 21
      wr(8'd9, 16'h0020);
      rd(8'd9, 16'h0020, "R8 enable readback");
      for (int i = 0; i < 109; i++) pulse((22'(1) << 21) | 22'(1), 9600, 9600);
      wr(8'd0, 16'h0001);
      rd(caddr(0, 0), 16'hF780, "R1 slice low");
      rd(caddr(0, 1), 16'h000F, "R1 slice mid");
      rd(caddr(0, 2), 16'h0000, "R1 slice top");
      rd(caddr(0, 3), 16'h0000, "R9 slice gap");
      rd(8'd4, 16'h0000, "R6 no wrap yet");
      check(16'(ovf_irq), 16'h0, "R8 irq before wrap");
      pulse((22'(1) << 21) | 22'(1), 9600, 9600);
      check(16'(ovf_irq), 16'h1, "R8 irq after enabled wrap");
      wr(8'd0, 16'h0003);
      rd(caddr(0, 0), 16'h1D00, "R6 wrapped value");
      rd(caddr(21, 1), 16'h0000, "R6 wrapped mid");
      rd(8'd5, 16'h0020, "R6 flag 21 in word 1");
      check(16'(ovf_irq), 16'h0, "R8 irq after read");
      rd(8'd5, 16'h0000, "R7 word cleared by read");
      rd(8'd4, 16'h0001, "R7 flag 0 held while masked");
      rd(8'd4, 16'h0000, "R7 word 0 cleared");

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule